// File: doc/BRIEF.md
# External Interrupt Request Controller

This block sits between eight active-low external interrupt request pins, one active-low non-maskable request pin and a processor core. It synchronizes every pin and detects falling edges. It keeps sticky pending state for edge-triggered sources and resolves priority. The winner goes to the core as a single held request: a valid flag, an 8-bit vector and a non-maskable flag. The request stays held until the core returns a one-cycle acknowledge.

A two-bit mode field chooses how the eight request pins are read. In the dedicated mode, every pin is a separate source, and a per-pin sensitivity bit makes it respond either to a low level or to a falling edge. In the expanded mode, the eight pins together carry one level-sensitive vector. In the mixed mode, the upper three pins stay dedicated sources. The lower five pins give the upper bits of a vector whose three lowest bits are the constant 010. Both configuration fields are loaded through simple write strobes.

Top module: `xint_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all pending state and drops `req_valid`. It selects the dedicated mode and makes every pin level-sensitive.
- R2: A level-sensitive dedicated pin held low raises `req_valid` on the third rising clock edge after the pin goes low, behind a two-stage synchronizer.
- R3: When a pin's sensitivity bit is 1, that pin is edge-triggered. A synchronized high-to-low transition sets a sticky pending bit, and `req_valid` rises one edge after that bit is set. The request survives the pin returning high, and only an acknowledge of that source clears it.
- R4: A level-sensitive source is pending only while its synchronized pin is low. Once the pin is high and the held request is acknowledged, no further request follows.
- R5: Among dedicated sources the highest pin index wins. The reported vector is the pin index, zero-extended to 8 bits.
- R6: In the expanded mode (mode value 01), an all-ones pin pattern means no request. Any other pattern is a request with vector equal to the bitwise inverse of the synchronized pins.
- R7: In the mixed mode (mode value 10), pins 7 to 5 are dedicated sources and pins 4 to 0 are a vector source. The vector is {inverted pins 4:0, 3'b010}, and all-ones on pins 4:0 means no vector request. Any dedicated request outranks the vector request.
- R8: A synchronized falling edge on `nmi_n` sets a sticky pending bit that outranks every other source. It is reported with `req_nmi` = 1 and vector 0, and its acknowledge clears it.
- R9: While `req_valid` is high and `ack` is low, `req_valid`, `req_vector` and `req_nmi` hold their values. An acknowledge drops `req_valid` for at least one cycle, and the next request can be presented on the edge after that.
- R10: Mode values 00 and 11 both select the dedicated mode. Mode and sensitivity writes take effect on the clock edge at which the strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_n | input | 8 | External interrupt request pins, active low |
| nmi_n | input | 1 | Non-maskable request pin, active low, falling-edge triggered |
| mode_we | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 2 | Mode: 00/11 dedicated, 01 expanded, 10 mixed |
| sens_we | input | 1 | Write strobe for the sensitivity field |
| sens_wdata | input | 8 | Per-pin sensitivity: 1 falling edge, 0 low level |
| ack | input | 1 | One-cycle acknowledge of the held request |
| req_valid | output | 1 | A request is being presented |
| req_vector | output | 8 | Vector of the presented request |
| req_nmi | output | 1 | The presented request is the non-maskable one |

## Verification
A level request reaches `req_valid` three edges after the pin changes. An edge request or a non-maskable request needs four edges, because of the extra pending stage. After an acknowledge, the next request appears two edges later. The bench steps a behavioural model on every rising edge, fed by the inputs sampled at that edge, and compares all three outputs with the model at every falling edge. The stimulus also changes only at falling edges, and the targeted checks wait exactly those edge counts before they sample, so each expected value is read in the cycle it is due.

// File: rtl/xint_ctrl.sv
module xint_ctrl #(
  parameter int NPIN = 8,
  parameter int MIX_DED = 3,
  parameter logic [MIX_DED-1:0] MIX_TAIL = 3'b010
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] irq_n,
  input  logic            nmi_n,
  input  logic            mode_we,
  input  logic [1:0]      mode_wdata,
  input  logic            sens_we,
  input  logic [NPIN-1:0] sens_wdata,
  input  logic            ack,
  output logic            req_valid,
  output logic [NPIN-1:0] req_vector,
  output logic            req_nmi
);
  localparam int VB = NPIN - MIX_DED;
  localparam int IW = $clog2(NPIN);

  logic [NPIN:0]   s1, s2, s3;
  logic [1:0]      mode;
  logic [NPIN-1:0] sens, pend, ded_en, ded_req, fall, clr_mask, vvec;
  logic            nmi_pend, req_ded, top_hit, vreq, ack_fire;
  logic [IW-1:0]   top_idx, cur_idx;

  wire is_exp = (mode == 2'b01);
  wire is_mix = (mode == 2'b10);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '1;
      s2 <= '1;
      s3 <= '1;
    end else begin
      s1 <= {nmi_n, irq_n};
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign fall     = s3[NPIN-1:0] & ~s2[NPIN-1:0];
  assign ack_fire = ack & req_valid;
  assign clr_mask = (ack_fire && req_ded) ? (NPIN'(1) << cur_idx) : '0;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign ded_en[i]  = is_exp ? 1'b0 : (is_mix ? ((i >= VB) ? 1'b1 : 1'b0) : 1'b1);
    assign ded_req[i] = ded_en[i] & (sens[i] ? pend[i] : ~s2[i]);
  end

  always_comb begin
    top_hit = 1'b0;
    top_idx = '0;
    for (int i = 0; i < NPIN; i++) begin
      if (ded_req[i]) begin
        top_hit = 1'b1;
        top_idx = IW'(i);
      end
    end
  end

  always_comb begin
    vreq = 1'b0;
    vvec = '0;
    if (is_exp) begin
      vreq = ~&s2[NPIN-1:0];
      vvec = ~s2[NPIN-1:0];
    end else if (is_mix) begin
      vreq = ~&s2[VB-1:0];
      vvec = {~s2[VB-1:0], MIX_TAIL};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= 2'b00;
      sens     <= '0;
      pend     <= '0;
      nmi_pend <= 1'b0;
    end else begin
      if (mode_we) mode <= mode_wdata;
      if (sens_we) sens <= sens_wdata;
      pend     <= (pend & ~clr_mask) | (fall & sens & ded_en);
      nmi_pend <= (nmi_pend & ~(ack_fire & req_nmi)) | (s3[NPIN] & ~s2[NPIN]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid  <= 1'b0;
      req_vector <= '0;
      req_nmi    <= 1'b0;
      req_ded    <= 1'b0;
      cur_idx    <= '0;
    end else if (ack_fire) begin
      req_valid <= 1'b0;
    end else if (!req_valid && (nmi_pend || top_hit || vreq)) begin
      req_valid  <= 1'b1;
      req_nmi    <= nmi_pend;
      req_ded    <= !nmi_pend && top_hit;
      cur_idx    <= top_idx;
      req_vector <= nmi_pend ? '0 : (top_hit ? NPIN'(top_idx) : vvec);
    end
  end
endmodule

module xint_ctrl_chk #(
  parameter int NPIN = 8,
  parameter int MIX_DED = 3,
  parameter logic [MIX_DED-1:0] MIX_TAIL = 3'b010
) (
  input logic            clk,
  input logic            rst,
  input logic            ack,
  input logic            req_valid,
  input logic [NPIN-1:0] req_vector,
  input logic            req_nmi,
  input logic [1:0]      mode
);
  AST_RST_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !req_valid); // R1
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    req_valid && !ack |=> req_valid && $stable(req_vector) && $stable(req_nmi)); // R9
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    req_valid && ack |=> !req_valid); // R9
  AST_NMI_VEC: assert property (@(posedge clk) disable iff (rst)
    req_nmi && req_valid |-> req_vector == '0); // R8
  AST_MIX_TAIL: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) && !req_nmi && $past(mode) == 2'b10 && req_vector >= NPIN
    |-> req_vector[MIX_DED-1:0] == MIX_TAIL); // R7
  AST_EXP_NONZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) && !req_nmi && $past(mode) == 2'b01 |-> req_vector != '0); // R6
endmodule

bind xint_ctrl xint_ctrl_chk #(.NPIN(NPIN), .MIX_DED(MIX_DED), .MIX_TAIL(MIX_TAIL)) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .req_valid(req_valid),
  .req_vector(req_vector), .req_nmi(req_nmi), .mode(mode)
);

// File: tb/xint_ctrl_tb.sv
module xint_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_n = 8'hFF;
  logic       nmi_n = 1'b1;
  logic       mode_we = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic       sens_we = 1'b0;
  logic [7:0] sens_wdata = 8'h00;
  logic       ack = 1'b0;
  logic       req_valid, req_nmi;
  logic [7:0] req_vector;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R1";
  bit    started = 0, done = 0;

  always #10 clk = ~clk;

  xint_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_n(irq_n), .nmi_n(nmi_n),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .sens_we(sens_we),
    .sens_wdata(sens_wdata), .ack(ack), .req_valid(req_valid),
    .req_vector(req_vector), .req_nmi(req_nmi)
  );

  logic [8:0] hq[$];
  int         m_mode, m_idx;
  logic [7:0] m_sens, m_pend, m_vec;
  logic       m_npend, m_valid, m_nmi, m_ded;

  always @(posedge clk) begin : model
    logic [7:0] cur, prev, en, clr, vv;
    logic fire, vr;
    int top;
    started = 1;
    if (rst) begin
      hq = '{9'h1FF, 9'h1FF, 9'h1FF};
      m_mode = 0; m_sens = 0; m_pend = 0; m_npend = 0;
      m_valid = 0; m_nmi = 0; m_ded = 0; m_vec = 0; m_idx = 0;
    end else begin
      cur = hq[1][7:0];
      prev = hq[2][7:0];
      for (int i = 0; i < 8; i++)
        en[i] = (m_mode == 1) ? 1'b0 : (m_mode == 2) ? (i >= 5) : 1'b1;
      top = -1;
      for (int i = 0; i < 8; i++)
        if (en[i] && (m_sens[i] ? m_pend[i] : !cur[i])) top = i;
      vr = 0; vv = 0;
      if (m_mode == 1) begin vr = (cur != 8'hFF); vv = ~cur; end
      if (m_mode == 2) begin vr = (cur[4:0] != 5'h1F); vv = {~cur[4:0], 3'b010}; end
      fire = ack && m_valid;
      clr = (fire && m_ded) ? (8'd1 << m_idx) : 8'd0;
      if (fire) m_valid = 0;
      else if (!m_valid && (m_npend || top >= 0 || vr)) begin
        m_valid = 1;
        m_nmi = m_npend;
        m_ded = !m_npend && top >= 0;
        m_idx = (top >= 0) ? top : 0;
        m_vec = m_npend ? 8'd0 : (top >= 0) ? 8'(top) : vv;
        if (m_npend) m_ded = 0;
      end
      begin
        logic nclr;
        nclr = fire && m_nmi && !m_valid;
        m_npend = (m_npend & ~nclr) | (hq[2][8] & ~hq[1][8]);
      end
      m_pend = (m_pend & ~clr) | (prev & ~cur & m_sens & en);
      if (mode_we) m_mode = mode_wdata;
      if (sens_we) m_sens = sens_wdata;
      hq.push_front({nmi_n, irq_n});
      void'(hq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      n_cmp++;
      if (req_valid !== m_valid || (m_valid && (req_vector !== m_vec || req_nmi !== m_nmi))) begin
        n_bad++;
        $display("FAIL %s cycle %0d: act valid=%b vec=%h nmi=%b exp valid=%b vec=%h nmi=%b",
                 tag, cyc, req_valid, req_vector, req_nmi, m_valid, m_vec, m_nmi);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic v, input logic [7:0] vec, input logic nmi, input string t);
    n_cmp++;
    if (req_valid !== v || (v && (req_vector !== vec || req_nmi !== nmi))) begin
      n_bad++;
      $display("FAIL %s: act valid=%b vec=%h nmi=%b exp valid=%b vec=%h nmi=%b",
               t, req_valid, req_vector, req_nmi, v, vec, nmi);
    end
  endtask

  task automatic pulse_ack;
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_we = 1'b1; mode_wdata = m;
    tick(1);
    mode_we = 1'b0;
  endtask

  task automatic summary;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: act cycles=%0d exp below 5000", cyc);
      summary();
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    tag = "R1"; expect_out(0, 8'h00, 0, "R1 reset idle");

    tag = "R2"; irq_n[2] = 1'b0;
    tick(2); expect_out(0, 8'h00, 0, "R2 not yet");
    tick(1); expect_out(1, 8'h02, 0, "R2 level request");
    tag = "R9"; tick(5); expect_out(1, 8'h02, 0, "R9 held");
    pulse_ack; expect_out(0, 8'h00, 0, "R9 drop after ack");
    tick(1); expect_out(1, 8'h02, 0, "R9 level re-request");
    tag = "R4"; irq_n[2] = 1'b1;
    tick(3); pulse_ack; tick(2); expect_out(0, 8'h00, 0, "R4 level gone");

    tag = "R5"; irq_n = 8'b1010_1101;
    tick(3); expect_out(1, 8'h06, 0, "R5 highest pin");
    irq_n[6] = 1'b1;
    tick(3); pulse_ack; tick(1); expect_out(1, 8'h04, 0, "R5 next pin");
    irq_n = 8'hFF; tick(3); pulse_ack; tick(2);

    tag = "R3"; sens_we = 1'b1; sens_wdata = 8'h08; tick(1); sens_we = 1'b0;
    irq_n[3] = 1'b0; tick(2); irq_n[3] = 1'b1;
    tick(1); expect_out(0, 8'h00, 0, "R3 pending stage");
    tick(1); expect_out(1, 8'h03, 0, "R3 edge request");
    tick(6); expect_out(1, 8'h03, 0, "R3 sticky");
    pulse_ack; tick(3); expect_out(0, 8'h00, 0, "R3 cleared by ack");

    tag = "R8"; nmi_n = 1'b0; tick(1); irq_n[5] = 1'b0; tick(1); nmi_n = 1'b1;
    tick(2); expect_out(1, 8'h00, 1, "R8 nmi wins");
    pulse_ack; tick(1); expect_out(1, 8'h05, 0, "R8 then dedicated");
    irq_n = 8'hFF; tick(3); pulse_ack; tick(2); expect_out(0, 8'h00, 0, "R8 nmi cleared");

    tag = "R6"; set_mode(2'b01);
    irq_n = 8'hA5; tick(3); expect_out(1, 8'h5A, 0, "R6 expanded vector");
    irq_n = 8'hFF; tick(3); pulse_ack; tick(2); expect_out(0, 8'h00, 0, "R6 all ones idle");
    irq_n = 8'h7F; tick(3); expect_out(1, 8'h80, 0, "R6 top pin vector");
    irq_n = 8'hFF; tick(3); pulse_ack; tick(2);

    tag = "R7"; set_mode(2'b10);
    irq_n = 8'b1011_0110; tick(3); expect_out(1, 8'h06, 0, "R7 dedicated outranks");
    irq_n[6] = 1'b1; tick(3); pulse_ack; tick(1); expect_out(1, 8'h4A, 0, "R7 mixed vector");
    irq_n = 8'hFF; tick(3); pulse_ack; tick(2); expect_out(0, 8'h00, 0, "R7 idle");

    tag = "R10"; set_mode(2'b11);
    irq_n[0] = 1'b0; tick(3); expect_out(1, 8'h00, 0, "R10 mode 11 dedicated");
    irq_n = 8'hFF; tick(3); pulse_ack; tick(3); expect_out(0, 8'h00, 0, "R10 idle");

    summary();
  end
endmodule